// File: doc/BRIEF.md
# Two-Instruction Fusion Detector

This decode-stage unit looks at a pair of adjacent 32-bit RV32I instructions in each cycle. It decides whether the pair forms one of a small set of idioms that a back end can execute as a single operation. The idioms are:

- an upper-immediate load completed by an add-immediate;
- a left shift followed by a right shift of the same register;
- a register add that forms the base address of a load or a store;
- a conditional branch that hops over one simple ALU instruction.

When the pair matches, the unit emits one fused micro-op descriptor. The descriptor gives the kind, at most two source registers, a single destination, and a combined 32-bit immediate. It also tells fetch to advance by two. When the pair does not match, the first instruction goes through unchanged and fetch advances by one.

Results are registered by default, one cycle after the slots are presented. A parameter selects a purely combinational variant instead. Separate parameters switch each idiom family on or off, and another sets the branch distance for the hop pattern.

Top module: `macro_fuse_detect`

## Requirements
- R1: While reset is asserted, and after it, until the first valid slot is sampled: uop_valid, uop_fused and advance are 0.
- R2: Results appear one clock after the inputs are sampled. When slot0_valid is 0, every output is 0. When the pair does not fuse, the outputs are as follows: uop_valid=1, uop_fused=0, uop_kind=0, advance=1, uop_insn=slot0_insn, uop_rs1/uop_rs2/uop_rd hold bits [19:15]/[24:20]/[11:7] of slot0_insn, and uop_imm=0.
- R3: LUI (opcode 0110111) or AUIPC (opcode 0010111) with rd=d, followed by ADDI (opcode 0010011, funct3 000), fuses. The kind is 1 for LUI and 2 for AUIPC. uop_imm = ({imm20,12'b0} + sign-extended imm12) mod 2^32. uop_rd=d and uop_rs1=uop_rs2=0.
- R4: SLLI (opcode 0010011, funct3 001, funct7 0) with rd=d, followed by SRLI or SRAI (funct3 101, funct7 0000000 or 0100000), fuses with kind 3. uop_rs1 is the SLLI source and uop_rs2=0. uop_imm bits [4:0] hold the left amount, bits [9:5] the right amount, and bit 10 is 1 for an arithmetic right shift. All other bits of uop_imm are 0.
- R5: ADD (opcode 0110011, funct3 0, funct7 0) with rd=d, followed by a load (opcode 0000011, funct3 000/001/010/100/101), fuses with kind 4. uop_rs1 and uop_rs2 are the ADD sources, and uop_imm is the sign-extended load offset.
- R6: ADD with rd=d followed by SB/SH/SW (opcode 0100011, funct3 000..010) fuses with kind 5 under three conditions. The store base must be d. The store data register must not be d. The store data register must equal one of the ADD sources. uop_rd=d, and uop_imm is the sign-extended store offset.
- R7: A conditional branch (opcode 1100011, funct3 not 010 or 011) with offset exactly +8 fuses with kind 6 under two conditions. The next instruction must have opcode 0010011 or 0110011. That instruction's rd must not be 0. uop_rs1 and uop_rs2 are the branch sources, uop_rd is the skipped instruction's rd, and uop_imm=8.
- R8: For R3, R4 and R5, both the source rs1 and the rd of the second instruction must equal d. Otherwise the pair does not fuse.
- R9: For R3 to R6, a pair with d=x0 never fuses.
- R10: When slot1_valid is 0, no fusion happens, whatever slot1_insn holds.
- R11: A fused result has uop_valid=1, uop_fused=1, advance=2, and uop_insn equal to the second instruction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| slot0_valid | input | 1 | First slot holds an instruction |
| slot0_insn | input | 32 | First instruction |
| slot1_valid | input | 1 | Second slot holds an instruction in the same group |
| slot1_insn | input | 32 | Second instruction |
| uop_valid | output | 1 | A descriptor is present |
| uop_fused | output | 1 | The descriptor covers both slots |
| uop_kind | output | 3 | 0 single, 1 LUI pair, 2 AUIPC pair, 3 shift pair, 4 indexed load, 5 indexed store, 6 branch hop |
| uop_rs1 | output | 5 | First source register |
| uop_rs2 | output | 5 | Second source register |
| uop_rd | output | 5 | Single destination register |
| uop_imm | output | 32 | Combined immediate or packed shift amounts |
| uop_insn | output | 32 | Raw instruction carried along (the second one when fused) |
| advance | output | 2 | Instructions consumed: 0, 1 or 2 |

## Verification
Directed pairs set the exact immediates for each idiom. These include a LUI whose sum with a negative ADDI wraps past 2^32, an arithmetic shift pair, and a store whose data register is the ADD destination. Each directed pair then changes one condition: a mismatched rd, d=x0, a branch distance of 12, or an empty second slot. Each such case shows whether that single condition alone blocks fusion. Random pairs are built mostly from the idiom templates, with random registers and a random bit flipped in the second word. They separate near-misses from true matches over the whole decoded field space. A small share of the random pairs also clears the slot-valid bits.

// File: rtl/fuse_pkg.sv
package fuse_pkg;

   localparam int ILEN = 32;
   localparam int XLEN = 32;
   localparam int RIDX = 5;
   localparam int KW   = 3;

   typedef enum logic [KW-1:0] {
      K_NONE  = 3'd0,
      K_LUI   = 3'd1,
      K_AUIPC = 3'd2,
      K_SHX   = 3'd3,
      K_LDX   = 3'd4,
      K_STX   = 3'd5,
      K_SFB   = 3'd6
   } fkind_e;

   localparam logic [6:0] OPC_LUI   = 7'b0110111;
   localparam logic [6:0] OPC_AUIPC = 7'b0010111;
   localparam logic [6:0] OPC_IMM   = 7'b0010011;
   localparam logic [6:0] OPC_REG   = 7'b0110011;
   localparam logic [6:0] OPC_LOAD  = 7'b0000011;
   localparam logic [6:0] OPC_STORE = 7'b0100011;
   localparam logic [6:0] OPC_BR    = 7'b1100011;

   // candidate produced by one idiom matcher
   typedef struct packed {
      logic            hit;
      fkind_e          kind;
      logic [RIDX-1:0] rs1;
      logic [RIDX-1:0] rs2;
      logic [RIDX-1:0] rd;
      logic [XLEN-1:0] imm;
   } fuop_t;

   // full descriptor leaving the block
   typedef struct packed {
      logic            valid;
      logic            fused;
      fkind_e          kind;
      logic [RIDX-1:0] rs1;
      logic [RIDX-1:0] rs2;
      logic [RIDX-1:0] rd;
      logic [XLEN-1:0] imm;
      logic [ILEN-1:0] insn;
      logic [1:0]      adv;
   } uop_out_t;

   function automatic logic [6:0] opc_of(input logic [ILEN-1:0] i);
      return i[6:0];
   endfunction
   function automatic logic [RIDX-1:0] rd_of(input logic [ILEN-1:0] i);
      return i[11:7];
   endfunction
   function automatic logic [RIDX-1:0] rs1_of(input logic [ILEN-1:0] i);
      return i[19:15];
   endfunction
   function automatic logic [RIDX-1:0] rs2_of(input logic [ILEN-1:0] i);
      return i[24:20];
   endfunction
   function automatic logic [2:0] f3_of(input logic [ILEN-1:0] i);
      return i[14:12];
   endfunction
   function automatic logic [6:0] f7_of(input logic [ILEN-1:0] i);
      return i[31:25];
   endfunction
   function automatic logic [XLEN-1:0] imm_i(input logic [ILEN-1:0] i);
      return {{20{i[31]}}, i[31:20]};
   endfunction
   function automatic logic [XLEN-1:0] imm_s(input logic [ILEN-1:0] i);
      return {{20{i[31]}}, i[31:25], i[11:7]};
   endfunction
   function automatic logic [XLEN-1:0] imm_b(input logic [ILEN-1:0] i);
      return {{19{i[31]}}, i[31], i[7], i[30:25], i[11:8], 1'b0};
   endfunction
   function automatic logic [XLEN-1:0] imm_u(input logic [ILEN-1:0] i);
      return {i[31:12], 12'b0};
   endfunction

endpackage

// File: rtl/fuse_match_upper.sv
module fuse_match_upper
   import fuse_pkg::*;
#(
   parameter bit ENABLE = 1'b1
) (
   input  logic [ILEN-1:0] i0,
   input  logic [ILEN-1:0] i1,
   output fuop_t           cand
);

   generate
      if (ENABLE) begin : g_on
         logic [RIDX-1:0] d;
         logic            head;
         logic            tail;
         always_comb begin
            d    = rd_of(i0);
            head = (opc_of(i0) == OPC_LUI) || (opc_of(i0) == OPC_AUIPC);
            tail = (opc_of(i1) == OPC_IMM) && (f3_of(i1) == 3'b000) &&
                   (rs1_of(i1) == d) && (rd_of(i1) == d);
            cand = '0;
            if (head && tail && (d != '0)) begin
               cand.hit  = 1'b1;
               cand.kind = (opc_of(i0) == OPC_LUI) ? K_LUI : K_AUIPC;
               cand.rd   = d;
               cand.imm  = imm_u(i0) + imm_i(i1);
            end
         end
      end else begin : g_off
         assign cand = '0;
      end
   endgenerate

endmodule

// File: rtl/fuse_match_shift.sv
module fuse_match_shift
   import fuse_pkg::*;
#(
   parameter bit ENABLE = 1'b1
) (
   input  logic [ILEN-1:0] i0,
   input  logic [ILEN-1:0] i1,
   output fuop_t           cand
);

   localparam logic [6:0] F7_LOGIC = 7'b0000000;
   localparam logic [6:0] F7_ARITH = 7'b0100000;

   generate
      if (ENABLE) begin : g_on
         logic [RIDX-1:0] d;
         logic            left;
         logic            right;
         logic            arith;
         always_comb begin
            d     = rd_of(i0);
            left  = (opc_of(i0) == OPC_IMM) && (f3_of(i0) == 3'b001) &&
                    (f7_of(i0) == F7_LOGIC);
            arith = (f7_of(i1) == F7_ARITH);
            right = (opc_of(i1) == OPC_IMM) && (f3_of(i1) == 3'b101) &&
                    ((f7_of(i1) == F7_LOGIC) || arith) &&
                    (rs1_of(i1) == d) && (rd_of(i1) == d);
            cand = '0;
            if (left && right && (d != '0)) begin
               cand.hit  = 1'b1;
               cand.kind = K_SHX;
               cand.rs1  = rs1_of(i0);
               cand.rd   = d;
               cand.imm  = {{(XLEN-11){1'b0}}, arith, rs2_of(i1), rs2_of(i0)};
            end
         end
      end else begin : g_off
         assign cand = '0;
      end
   endgenerate

endmodule

// File: rtl/fuse_match_mem.sv
module fuse_match_mem
   import fuse_pkg::*;
#(
   parameter bit EN_LOAD  = 1'b1,
   parameter bit EN_STORE = 1'b1
) (
   input  logic [ILEN-1:0] i0,
   input  logic [ILEN-1:0] i1,
   output fuop_t           cand
);

   logic [RIDX-1:0] d;
   logic            is_add;
   logic            ld_ok;
   logic            st_ok;

   always_comb begin
      d      = rd_of(i0);
      is_add = (opc_of(i0) == OPC_REG) && (f3_of(i0) == 3'b000) &&
               (f7_of(i0) == 7'b0) && (d != '0);
   end

   generate
      if (EN_LOAD) begin : g_ld
         always_comb begin
            ld_ok = (opc_of(i1) == OPC_LOAD) && (f3_of(i1) != 3'b011) &&
                    (f3_of(i1) <= 3'b101) && (rs1_of(i1) == d) &&
                    (rd_of(i1) == d);
         end
      end else begin : g_no_ld
         assign ld_ok = 1'b0;
      end
      if (EN_STORE) begin : g_st
         always_comb begin
            st_ok = (opc_of(i1) == OPC_STORE) && (f3_of(i1) <= 3'b010) &&
                    (rs1_of(i1) == d) && (rs2_of(i1) != d) &&
                    ((rs2_of(i1) == rs1_of(i0)) || (rs2_of(i1) == rs2_of(i0)));
         end
      end else begin : g_no_st
         assign st_ok = 1'b0;
      end
   endgenerate

   always_comb begin
      cand = '0;
      if (is_add && (ld_ok || st_ok)) begin
         cand.hit  = 1'b1;
         cand.kind = ld_ok ? K_LDX : K_STX;
         cand.rs1  = rs1_of(i0);
         cand.rs2  = rs2_of(i0);
         cand.rd   = d;
         cand.imm  = ld_ok ? imm_i(i1) : imm_s(i1);
      end
   end

endmodule

// File: rtl/fuse_match_sfb.sv
module fuse_match_sfb
   import fuse_pkg::*;
#(
   parameter bit ENABLE     = 1'b1,
   parameter int SFB_OFFSET = 8
) (
   input  logic [ILEN-1:0] br_insn,
   input  logic [6:0]      nx_opc,
   input  logic [RIDX-1:0] nx_rd,
   output fuop_t           cand
);

   localparam logic [XLEN-1:0] HOP = XLEN'(SFB_OFFSET);

   generate
      if (ENABLE) begin : g_on
         logic is_br;
         logic simple;
         always_comb begin
            is_br  = (opc_of(br_insn) == OPC_BR) &&
                     (f3_of(br_insn) != 3'b010) && (f3_of(br_insn) != 3'b011) &&
                     (imm_b(br_insn) == HOP);
            simple = ((nx_opc == OPC_IMM) || (nx_opc == OPC_REG)) && (nx_rd != '0);
            cand = '0;
            if (is_br && simple) begin
               cand.hit  = 1'b1;
               cand.kind = K_SFB;
               cand.rs1  = rs1_of(br_insn);
               cand.rs2  = rs2_of(br_insn);
               cand.rd   = nx_rd;
               cand.imm  = HOP;
            end
         end
      end else begin : g_off
         assign cand = '0;
      end
   endgenerate

endmodule

// File: rtl/macro_fuse_detect.sv
module macro_fuse_detect
   import fuse_pkg::*;
#(
   parameter bit EN_UPPER   = 1'b1,
   parameter bit EN_SHIFT   = 1'b1,
   parameter bit EN_LOAD    = 1'b1,
   parameter bit EN_STORE   = 1'b1,
   parameter bit EN_SFB     = 1'b1,
   parameter int SFB_OFFSET = 8,
   parameter bit OUT_REG    = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             slot0_valid,
   input  logic [31:0]      slot0_insn,
   input  logic             slot1_valid,
   input  logic [31:0]      slot1_insn,
   output logic             uop_valid,
   output logic             uop_fused,
   output logic [2:0]       uop_kind,
   output logic [4:0]       uop_rs1,
   output logic [4:0]       uop_rs2,
   output logic [4:0]       uop_rd,
   output logic [31:0]      uop_imm,
   output logic [31:0]      uop_insn,
   output logic [1:0]       advance
);

   localparam int NCAND = 4;

   generate
      if (SFB_OFFSET < 8 || (SFB_OFFSET % 4) != 0 || SFB_OFFSET > 4092) begin : g_bad_hop
         $error("SFB_OFFSET must be a multiple of 4 between 8 and 4092");
      end
   endgenerate

   fuop_t    cand [NCAND];
   fuop_t    pick;
   uop_out_t nxt;
   uop_out_t cur;

   fuse_match_upper #(.ENABLE(EN_UPPER)) u_upper (
      .i0(slot0_insn), .i1(slot1_insn), .cand(cand[0]));

   fuse_match_shift #(.ENABLE(EN_SHIFT)) u_shift (
      .i0(slot0_insn), .i1(slot1_insn), .cand(cand[1]));

   fuse_match_mem #(.EN_LOAD(EN_LOAD), .EN_STORE(EN_STORE)) u_mem (
      .i0(slot0_insn), .i1(slot1_insn), .cand(cand[2]));

   fuse_match_sfb #(.ENABLE(EN_SFB), .SFB_OFFSET(SFB_OFFSET)) u_sfb (
      .br_insn(slot0_insn), .nx_opc(opc_of(slot1_insn)), .nx_rd(rd_of(slot1_insn)),
      .cand(cand[3]));

   // first hit wins; the idiom families are disjoint on the first opcode
   always_comb begin
      pick = '0;
      for (int k = 0; k < NCAND; k++) begin
         if (!pick.hit && cand[k].hit) pick = cand[k];
      end
   end

   always_comb begin
      nxt = '0;
      if (slot0_valid) begin
         nxt.valid = 1'b1;
         if (slot1_valid && pick.hit) begin
            nxt.fused = 1'b1;
            nxt.kind  = pick.kind;
            nxt.rs1   = pick.rs1;
            nxt.rs2   = pick.rs2;
            nxt.rd    = pick.rd;
            nxt.imm   = pick.imm;
            nxt.insn  = slot1_insn;
            nxt.adv   = 2'd2;
         end else begin
            nxt.kind  = K_NONE;
            nxt.rs1   = rs1_of(slot0_insn);
            nxt.rs2   = rs2_of(slot0_insn);
            nxt.rd    = rd_of(slot0_insn);
            nxt.insn  = slot0_insn;
            nxt.adv   = 2'd1;
         end
      end
   end

   generate
      if (OUT_REG) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) cur <= '0;
            else        cur <= nxt;
         end
      end else begin : g_comb
         assign cur = nxt;
      end
   endgenerate

   assign uop_valid = cur.valid;
   assign uop_fused = cur.fused;
   assign uop_kind  = cur.kind;
   assign uop_rs1   = cur.rs1;
   assign uop_rs2   = cur.rs2;
   assign uop_rd    = cur.rd;
   assign uop_imm   = cur.imm;
   assign uop_insn  = cur.insn;
   assign advance   = cur.adv;

endmodule

// File: rtl/fuse_checker.sv
module fuse_checker
   import fuse_pkg::*;
#(
   parameter bit OUT_REG = 1'b1
) (
   input logic        clk,
   input logic        rst_n,
   input logic        slot0_valid,
   input logic [31:0] slot0_insn,
   input logic        slot1_valid,
   input logic [31:0] slot1_insn,
   input logic        uop_valid,
   input logic        uop_fused,
   input logic [2:0]  uop_kind,
   input logic [4:0]  uop_rd,
   input logic [31:0] uop_insn,
   input logic [1:0]  advance
);

   logic        q_v1;
   logic [31:0] q_i0;
   logic [31:0] q_i1;

   generate
      if (OUT_REG) begin : g_q
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               q_v1 <= 1'b0;
               q_i0 <= '0;
               q_i1 <= '0;
            end else begin
               q_v1 <= slot1_valid;
               q_i0 <= slot0_insn;
               q_i1 <= slot1_insn;
            end
         end
      end else begin : g_d
         assign q_v1 = slot1_valid;
         assign q_i0 = slot0_insn;
         assign q_i1 = slot1_insn;
      end
   endgenerate

   logic unused_v0;
   assign unused_v0 = slot0_valid;

   assert_pair_takes_two_R11: assert property (@(posedge clk) disable iff (!rst_n)
      uop_fused |-> (uop_valid && advance == 2'd2 && uop_kind != 3'd0 && uop_insn == q_i1));

   assert_idle_slot_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !uop_valid |-> (advance == 2'd0 && !uop_fused));

   assert_single_passes_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (uop_valid && !uop_fused) |-> (uop_insn == q_i0 && advance == 2'd1 && uop_kind == 3'd0));

   assert_needs_second_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !q_v1 |-> !uop_fused);

   assert_no_zero_dest_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (uop_fused && uop_kind != 3'd6) |-> (uop_rd != 5'd0));

   assert_dead_middle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (uop_fused && uop_kind >= 3'd1 && uop_kind <= 3'd4) |->
         (q_i1[19:15] == q_i0[11:7] && q_i1[11:7] == q_i0[11:7] && uop_rd == q_i0[11:7]));

endmodule

bind macro_fuse_detect fuse_checker #(.OUT_REG(OUT_REG)) u_fuse_checker (
   .clk(clk), .rst_n(rst_n),
   .slot0_valid(slot0_valid), .slot0_insn(slot0_insn),
   .slot1_valid(slot1_valid), .slot1_insn(slot1_insn),
   .uop_valid(uop_valid), .uop_fused(uop_fused), .uop_kind(uop_kind),
   .uop_rd(uop_rd), .uop_insn(uop_insn), .advance(advance));

// File: tb/test_macro_fuse_detect.sv
`timescale 1ns/1ps
module test_macro_fuse_detect;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        v0 = 1'b0, v1 = 1'b0;
   logic [31:0] i0 = '0, i1 = '0;
   logic        o_valid, o_fused;
   logic [2:0]  o_kind;
   logic [4:0]  o_rs1, o_rs2, o_rd;
   logic [31:0] o_imm, o_insn;
   logic [1:0]  o_adv;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   macro_fuse_detect i_macro_fuse_detect (
      .clk(clk), .rst_n(rst_n),
      .slot0_valid(v0), .slot0_insn(i0), .slot1_valid(v1), .slot1_insn(i1),
      .uop_valid(o_valid), .uop_fused(o_fused), .uop_kind(o_kind),
      .uop_rs1(o_rs1), .uop_rs2(o_rs2), .uop_rd(o_rd), .uop_imm(o_imm),
      .uop_insn(o_insn), .advance(o_adv));

   typedef struct packed {
      logic        ov, fv;
      logic [2:0]  k;
      logic [4:0]  s1, s2, d;
      logic [31:0] im, ins;
      logic [1:0]  c;
   } exp_t;

   // instruction builders
   function automatic logic [31:0] enc_u(logic [6:0] op, logic [4:0] rd, logic [19:0] u);
      return {u, rd, op};
   endfunction
   function automatic logic [31:0] enc_i(logic [6:0] op, logic [4:0] rd, logic [2:0] f3,
                                         logic [4:0] rs1, logic [11:0] im);
      return {im, rs1, f3, rd, op};
   endfunction
   function automatic logic [31:0] enc_r(logic [6:0] f7, logic [4:0] rs2, logic [4:0] rs1,
                                         logic [2:0] f3, logic [4:0] rd, logic [6:0] op);
      return {f7, rs2, rs1, f3, rd, op};
   endfunction
   function automatic logic [31:0] enc_s(logic [2:0] f3, logic [4:0] rs1, logic [4:0] rs2,
                                         logic [11:0] im);
      return {im[11:5], rs2, rs1, f3, im[4:0], 7'b0100011};
   endfunction
   function automatic logic [31:0] enc_b(logic [2:0] f3, logic [4:0] rs1, logic [4:0] rs2,
                                         logic [12:0] off);
      return {off[12], off[10:5], rs2, rs1, f3, off[4:1], off[11], 7'b1100011};
   endfunction

   // reference model written from the requirements
   function automatic exp_t model(logic a0, logic [31:0] x, logic a1, logic [31:0] y);
      exp_t e;
      logic [4:0] d;
      logic [31:0] boff;
      logic add_ok;
      e = '0;
      if (!a0) return e;
      e.ov = 1'b1; e.c = 2'd1; e.ins = x;
      e.s1 = x[19:15]; e.s2 = x[24:20]; e.d = x[11:7];
      if (!a1) return e;
      d = x[11:7];
      add_ok = (x[6:0] == 7'h33) && (x[14:12] == 3'd0) && (x[31:25] == 7'd0) && (d != 0);
      boff = {{19{x[31]}}, x[31], x[7], x[30:25], x[11:8], 1'b0};
      if ((x[6:0] == 7'h37 || x[6:0] == 7'h17) && d != 0 &&
          y[6:0] == 7'h13 && y[14:12] == 3'd0 && y[19:15] == d && y[11:7] == d) begin
         e.k = (x[6:0] == 7'h37) ? 3'd1 : 3'd2;
         e.s1 = 0; e.s2 = 0; e.d = d;
         e.im = {x[31:12], 12'h000} + {{20{y[31]}}, y[31:20]};
         e.fv = 1'b1;
      end else if (x[6:0] == 7'h13 && x[14:12] == 3'd1 && x[31:25] == 0 && d != 0 &&
                   y[6:0] == 7'h13 && y[14:12] == 3'd5 &&
                   (y[31:25] == 7'h00 || y[31:25] == 7'h20) &&
                   y[19:15] == d && y[11:7] == d) begin
         e.k = 3'd3; e.s1 = x[19:15]; e.s2 = 0; e.d = d;
         e.im = {21'd0, y[30], y[24:20], x[24:20]};
         e.fv = 1'b1;
      end else if (add_ok && y[6:0] == 7'h03 &&
                   (y[14:12] == 0 || y[14:12] == 1 || y[14:12] == 2 ||
                    y[14:12] == 4 || y[14:12] == 5) &&
                   y[19:15] == d && y[11:7] == d) begin
         e.k = 3'd4; e.s1 = x[19:15]; e.s2 = x[24:20]; e.d = d;
         e.im = {{20{y[31]}}, y[31:20]};
         e.fv = 1'b1;
      end else if (add_ok && y[6:0] == 7'h23 && y[14:12] <= 3'd2 &&
                   y[19:15] == d && y[24:20] != d &&
                   (y[24:20] == x[19:15] || y[24:20] == x[24:20])) begin
         e.k = 3'd5; e.s1 = x[19:15]; e.s2 = x[24:20]; e.d = d;
         e.im = {{20{y[31]}}, y[31:25], y[11:7]};
         e.fv = 1'b1;
      end else if (x[6:0] == 7'h63 && x[14:12] != 3'd2 && x[14:12] != 3'd3 &&
                   boff == 32'd8 && (y[6:0] == 7'h13 || y[6:0] == 7'h33) &&
                   y[11:7] != 0) begin
         e.k = 3'd6; e.s1 = x[19:15]; e.s2 = x[24:20]; e.d = y[11:7];
         e.im = 32'd8;
         e.fv = 1'b1;
      end
      if (e.fv) begin e.c = 2'd2; e.ins = y; end
      return e;
   endfunction

   task automatic apply(logic a0, logic [31:0] x, logic a1, logic [31:0] y);
      @(negedge clk);
      v0 = a0; i0 = x; v1 = a1; i1 = y;
      @(posedge clk);
      #2;
   endtask

   task automatic compare(exp_t e, string tag);
      exp_t got;
      got = {o_valid, o_fused, o_kind, o_rs1, o_rs2, o_rd, o_imm, o_insn, o_adv};
      total++;
      if (got !== e) begin
         bad++;
         $display("FAIL %s: got v=%0b f=%0b k=%0d rs1=%0d rs2=%0d rd=%0d imm=%h insn=%h adv=%0d expected v=%0b f=%0b k=%0d rs1=%0d rs2=%0d rd=%0d imm=%h insn=%h adv=%0d",
                  tag, got.ov, got.fv, got.k, got.s1, got.s2, got.d, got.im, got.ins, got.c,
                  e.ov, e.fv, e.k, e.s1, e.s2, e.d, e.im, e.ins, e.c);
      end
   endtask

   task automatic lit(logic [2:0] k, logic [31:0] im, logic [1:0] c, string tag);
      total++;
      if (o_kind !== k || o_imm !== im || o_adv !== c) begin
         bad++;
         $display("FAIL %s: got kind=%0d imm=%h adv=%0d expected kind=%0d imm=%h adv=%0d",
                  tag, o_kind, o_imm, o_adv, k, im, c);
      end
   endtask

   task automatic pair(logic a0, logic [31:0] x, logic a1, logic [31:0] y, string tag);
      apply(a0, x, a1, y);
      compare(model(a0, x, a1, y), tag);
   endtask

   function automatic logic [31:0] rnd_pair_first(int pat, logic [4:0] d, logic [4:0] a,
                                                  logic [4:0] b);
      case (pat)
         0: return enc_u(7'h37, d, 20'($urandom));
         1: return enc_u(7'h17, d, 20'($urandom));
         2: return enc_i(7'h13, d, 3'd1, a, {7'd0, 5'($urandom)});
         3, 4: return enc_r(7'd0, b, a, 3'd0, d, 7'h33);
         5: return enc_b(3'($urandom % 2) + 3'($urandom % 2) * 3'd4, a, b,
                         ($urandom % 3 == 0) ? 13'd12 : 13'd8);
         default: return 32'($urandom);
      endcase
   endfunction

   function automatic logic [31:0] rnd_pair_second(int pat, logic [4:0] d, logic [4:0] a,
                                                   logic [4:0] b);
      case (pat)
         0, 1: return enc_i(7'h13, d, 3'd0, d, 12'($urandom));
         2: return enc_i(7'h13, d, 3'd5, d, {($urandom % 2 == 0) ? 7'h20 : 7'h00, 5'($urandom)});
         3: return enc_i(7'h03, d, 3'($urandom % 6), d, 12'($urandom));
         4: return enc_s(3'($urandom % 3), d, ($urandom % 2 == 0) ? a : b, 12'($urandom));
         5: return enc_i(($urandom % 2 == 0) ? 7'h13 : 7'h33, 5'($urandom), 3'($urandom),
                         5'($urandom), 12'($urandom));
         default: return 32'($urandom);
      endcase
   endfunction

   initial begin : watchdog
      #1600000;
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog: got hung run expected completion");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin : main
      void'($urandom(32'd20240611));
      // R1: reset state
      repeat (2) @(posedge clk);
      #2;
      total++;
      if (o_valid !== 1'b0 || o_fused !== 1'b0 || o_adv !== 2'd0) begin
         bad++;
         $display("FAIL R1: got v=%0b f=%0b adv=%0d expected 0 0 0", o_valid, o_fused, o_adv);
      end
      @(negedge clk);
      rst_n = 1'b1;

      // R3 LUI + ADDI with a negative low part
      pair(1, enc_u(7'h37, 5'd5, 20'h12345), 1, enc_i(7'h13, 5'd5, 3'd0, 5'd5, 12'hFFF), "R3");
      lit(3'd1, 32'h12344FFF, 2'd2, "R3");
      // R3 wraparound
      pair(1, enc_u(7'h37, 5'd7, 20'hFFFFF), 1, enc_i(7'h13, 5'd7, 3'd0, 5'd7, 12'h800), "R3");
      lit(3'd1, 32'hFFFFE800, 2'd2, "R3");
      // R3 AUIPC flavour
      pair(1, enc_u(7'h17, 5'd9, 20'h00001), 1, enc_i(7'h13, 5'd9, 3'd0, 5'd9, 12'h010), "R3");
      lit(3'd2, 32'h00001010, 2'd2, "R3");
      // R4 arithmetic extract
      pair(1, enc_i(7'h13, 5'd3, 3'd1, 5'd4, 12'd24), 1,
           enc_i(7'h13, 5'd3, 3'd5, 5'd3, {7'h20, 5'd24}), "R4");
      lit(3'd3, 32'h00000718, 2'd2, "R4");
      // R5 indexed load
      pair(1, enc_r(7'd0, 5'd2, 5'd1, 3'd0, 5'd6, 7'h33), 1,
           enc_i(7'h03, 5'd6, 3'd2, 5'd6, 12'd12), "R5");
      lit(3'd4, 32'd12, 2'd2, "R5");
      // R6 indexed store, data from an ADD source
      pair(1, enc_r(7'd0, 5'd11, 5'd10, 3'd0, 5'd8, 7'h33), 1,
           enc_s(3'd2, 5'd8, 5'd11, 12'hFFC), "R6");
      lit(3'd5, 32'hFFFFFFFC, 2'd2, "R6");
      // R6 store data equal to d: not fused
      pair(1, enc_r(7'd0, 5'd12, 5'd11, 3'd0, 5'd11, 7'h33), 1,
           enc_s(3'd2, 5'd11, 5'd11, 12'd0), "R6");
      lit(3'd0, 32'd0, 2'd1, "R6");
      // R7 branch hop
      pair(1, enc_b(3'd0, 5'd1, 5'd2, 13'd8), 1, enc_i(7'h13, 5'd5, 3'd0, 5'd5, 12'd1), "R7");
      lit(3'd6, 32'd8, 2'd2, "R7");
      pair(1, enc_b(3'd0, 5'd1, 5'd2, 13'd12), 1, enc_i(7'h13, 5'd5, 3'd0, 5'd5, 12'd1), "R7");
      lit(3'd0, 32'd0, 2'd1, "R7");
      // R8 destination mismatch
      pair(1, enc_u(7'h37, 5'd5, 20'h1), 1, enc_i(7'h13, 5'd6, 3'd0, 5'd5, 12'd1), "R8");
      lit(3'd0, 32'd0, 2'd1, "R8");
      // R9 x0 destination
      pair(1, enc_u(7'h37, 5'd0, 20'h1), 1, enc_i(7'h13, 5'd0, 3'd0, 5'd0, 12'd1), "R9");
      lit(3'd0, 32'd0, 2'd1, "R9");
      // R10 second slot empty
      pair(1, enc_u(7'h37, 5'd5, 20'h1), 0, enc_i(7'h13, 5'd5, 3'd0, 5'd5, 12'd1), "R10");
      lit(3'd0, 32'd0, 2'd1, "R10");
      // R2 empty first slot and plain pass-through
      pair(0, 32'hDEADBEEF, 1, 32'h12345678, "R2");
      lit(3'd0, 32'd0, 2'd0, "R2");
      pair(1, enc_r(7'd0, 5'd3, 5'd2, 3'd0, 5'd1, 7'h33), 1,
           enc_r(7'd0, 5'd5, 5'd4, 3'd0, 5'd6, 7'h33), "R2");
      // R11 fused descriptor carries the second word
      total++;
      pair(1, enc_u(7'h37, 5'd4, 20'hABCDE), 1, enc_i(7'h13, 5'd4, 3'd0, 5'd4, 12'd5), "R11");
      if (o_insn !== enc_i(7'h13, 5'd4, 3'd0, 5'd4, 12'd5)) begin
         bad++;
         $display("FAIL R11: got insn=%h expected %h", o_insn, enc_i(7'h13, 5'd4, 3'd0, 5'd4, 12'd5));
      end

      // random mix over all idioms, R3 R4 R5 R6 R7 R8 R9 R10
      for (int n = 0; n < 4000; n++) begin
         int pat;
         logic [4:0] d, a, b;
         logic [31:0] x, y;
         logic a0, a1;
         pat = int'($urandom % 7);
         d = ($urandom % 8 == 0) ? 5'd0 : 5'($urandom % 31 + 1);
         a = 5'($urandom);
         b = 5'($urandom);
         x = rnd_pair_first(pat, d, a, b);
         y = rnd_pair_second(pat, d, a, b);
         if ($urandom % 5 == 0) y = y ^ (32'd1 << ($urandom % 32));
         a0 = ($urandom % 20 != 0);
         a1 = ($urandom % 10 != 0);
         pair(a0, x, a1, y, "R3-mix");
      end

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule